// File: doc/BRIEF.md
# Event-Remapped Performance Counter Bank

This block counts micro-architectural events reported by a branch-prediction unit. The predictor raises up to twenty single-cycle strobes, each tied to a 5-bit event number. A remap stage places strobe `n` on slot `n+1` of a 256-slot event bus. Slot 0 therefore stays free as the "no event" code, and every slot above the last strobe is held low.

Sixteen counter positions form the bank. Position 0 is a free-running cycle counter. Position 2 counts retired instructions. Positions 3 to 15 are thirteen programmable counters, and each one has a selector register that names the event-bus slot it counts. Position 1 is reserved.

A write port lets software load counters and selectors. A separate read address returns any register within the same cycle.

Top module: `perf_counter_bank`

## Requirements
- R1: Input `bp_evt_strb` carries 20 strobes. Strobe bit `n` drives `evt_bus` slot `n+1` combinationally, in the same cycle.
- R2: `evt_bus` slot 0 is the no-event code and is never high.
- R3: `evt_bus` slots 21 to 255 are always low.
- R4: Counter index 0 (cycle) increments on every clock edge out of reset unless it is written in that cycle.
- R5: Counter index 2 (retired) increments on each edge where `retire` is high.
- R6: A programmable counter (index 3 to 15) increments by one on an edge where the bus slot named by its 9-bit selector is high. It never advances by more than one per edge, even when several strobes fire together.
- R7: A programmable counter whose selector is 0, or 256 or above, never increments.
- R8: All counters are 64 bits wide and wrap from all-ones to zero.
- R9: A write takes effect on the next edge and overrides an increment in the same cycle. A counter write loads all 64 bits of `wr_data`. A selector write loads `wr_data[8:0]`.
- R10: A synchronous active-high `rst` clears every counter and selector to zero.
- R11: Address bit 4 selects the space: 0 for counters, 1 for selectors. Bits 3:0 give the index. Counter index 1 and selector indices 0 to 2 always read zero, and writes to them are ignored.
- R12: `rd_data` follows `rd_addr` combinationally. Selector reads are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_evt_strb | input | 20 | Event strobes from the branch predictor |
| retire | input | 1 | One instruction retired this cycle |
| wr_en | input | 1 | Software write enable |
| wr_addr | input | 5 | Write address (space bit plus index) |
| wr_data | input | 64 | Write data |
| rd_addr | input | 5 | Read address (space bit plus index) |
| rd_data | output | 64 | Read data for `rd_addr` |
| evt_bus | output | 256 | Remapped event bus |

## Verification
Some properties are checked by assertions on every cycle:
- the quiet slot 0 and the quiet upper slots of the bus;
- the one-slot offset of the remap;
- the per-edge step of each counter (cycle, selected event, idle selector, at most one per edge);
- the rule that a write wins over an increment.

Other behaviour only the bench scenarios can show. These are the exact totals after bursts of simultaneous strobes, the wrap from all-ones, the out-of-range selectors, the reserved addresses that ignore writes, and the reset values read back through the port.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    parameter int unsigned NUM_STROBES = 20;
    parameter int unsigned BUS_W       = 256;
    parameter int unsigned CNT_W       = 64;
    parameter int unsigned SEL_W       = 9;
    parameter int unsigned NUM_CNT     = 16;
    parameter int unsigned FIRST_PROG  = 3;
    parameter int unsigned IDX_CYCLE   = 0;
    parameter int unsigned IDX_RETIRE  = 2;

    localparam int unsigned IDX_W  = $clog2(NUM_CNT);
    localparam int unsigned ADDR_W = IDX_W + 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic {
        SPACE_CNT = 1'b0,
        SPACE_SEL = 1'b1
    } space_e;

    typedef struct packed {
        space_e           space;
        logic [IDX_W-1:0] idx;
    } reg_addr_t;

    typedef struct packed {
        logic      en;
        reg_addr_t addr;
        cnt_t      data;
    } sw_wr_t;

    typedef enum logic [1:0] {
        CNT_FREE,
        CNT_RETIRE,
        CNT_EVENT,
        CNT_NONE
    } cnt_kind_e;

    // Role of each counter position.
    function automatic cnt_kind_e kind_of(int unsigned i);
        if (i == IDX_CYCLE)       return CNT_FREE;
        else if (i == IDX_RETIRE) return CNT_RETIRE;
        else if (i >= FIRST_PROG) return CNT_EVENT;
        else                      return CNT_NONE;
    endfunction

    // Does the software write target register i in space s?
    function automatic logic hits(sw_wr_t w, space_e s, int unsigned i);
        return w.en && (w.addr.space == s) && (w.addr.idx == IDX_W'(i));
    endfunction
endpackage

// File: rtl/hpc_event_remap.sv
module hpc_event_remap #(
    parameter int unsigned NS = 20,
    parameter int unsigned BW = 256
) (
    input  logic [NS-1:0] strb,
    output logic [BW-1:0] bus
);
    // Slot 0 is reserved; strobe n lands on slot n+1; the rest stay low.
    for (genvar s = 0; s < BW; s++) begin : g_slot
        if (s >= 1 && s <= NS) begin : g_live
            assign bus[s] = strb[s-1];
        end else begin : g_tie
            assign bus[s] = 1'b0;
        end
    end
endmodule

// File: rtl/hpc_event_pick.sv
module hpc_event_pick #(
    parameter int unsigned BW = 256,
    parameter int unsigned SW = 9
) (
    input  logic [BW-1:0] bus,
    input  logic [SW-1:0] sel,
    output logic          hit
);
    localparam int unsigned BIDX_W = $clog2(BW);

    logic in_range;

    // Selector 0 and any selector past the bus never count.
    assign in_range = (sel != '0) && (sel < SW'(BW));
    assign hit      = in_range ? bus[sel[BIDX_W-1:0]] : 1'b0;
endmodule

// File: rtl/hpc_counter.sv
module hpc_counter #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             inc,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] q;

    // A software write beats an increment in the same cycle; the sum wraps.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_hit) begin
            q <= wr_data;
        end else if (inc) begin
            q <= q + WIDTH'(1);
        end
    end

    assign value = q;
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import hpc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STROBES-1:0] bp_evt_strb,
    input  logic                   retire,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CNT_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [CNT_W-1:0]       rd_data,
    output logic [BUS_W-1:0]       evt_bus
);
    sw_wr_t              wr;
    reg_addr_t           rd;
    cnt_t [NUM_CNT-1:0]  cnt_all;
    sel_t [NUM_CNT-1:0]  sel_all;

    always_comb begin
        wr.en   = wr_en;
        wr.addr = reg_addr_t'(wr_addr);
        wr.data = wr_data;
        rd      = reg_addr_t'(rd_addr);
    end

    hpc_event_remap #(.NS(NUM_STROBES), .BW(BUS_W)) u_remap (
        .strb (bp_evt_strb),
        .bus  (evt_bus)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_pos
        if (kind_of(i) == CNT_NONE) begin : g_none
            assign cnt_all[i] = '0;
            assign sel_all[i] = '0;
        end else begin : g_cnt
            logic inc;

            if (kind_of(i) == CNT_FREE) begin : g_free
                assign inc        = 1'b1;
                assign sel_all[i] = '0;
            end else if (kind_of(i) == CNT_RETIRE) begin : g_ret
                assign inc        = retire;
                assign sel_all[i] = '0;
            end else begin : g_evt
                sel_t sel_q;

                always_ff @(posedge clk) begin
                    if (rst) begin
                        sel_q <= '0;
                    end else if (hits(wr, SPACE_SEL, i)) begin
                        sel_q <= wr.data[SEL_W-1:0];
                    end
                end

                assign sel_all[i] = sel_q;

                hpc_event_pick #(.BW(BUS_W), .SW(SEL_W)) u_pick (
                    .bus (evt_bus),
                    .sel (sel_q),
                    .hit (inc)
                );
            end

            hpc_counter #(.WIDTH(CNT_W)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .wr_hit  (hits(wr, SPACE_CNT, i)),
                .wr_data (wr.data),
                .inc     (inc),
                .value   (cnt_all[i])
            );
        end
    end

    // Combinational read of registered state; selectors zero-extended.
    always_comb begin
        if (rd.space == SPACE_CNT) begin
            rd_data = cnt_all[rd.idx];
        end else begin
            rd_data = CNT_W'(sel_all[rd.idx]);
        end
    end
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk
    import hpc_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_STROBES-1:0] strb,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [CNT_W-1:0]       wr_data,
    input logic [BUS_W-1:0]       evt_bus,
    input cnt_t [NUM_CNT-1:0]     cnt_all,
    input sel_t [NUM_CNT-1:0]     sel_all
);
    localparam int unsigned BIDX_W = $clog2(BUS_W);

    // R2: the no-event slot never rises
    assert_slot0_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !evt_bus[0]);

    // R3: slots past the last strobe stay low
    assert_upper_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        evt_bus[BUS_W-1:NUM_STROBES+1] == '0);

    // R1: one-slot offset between strobe and bus
    assert_remap_offset_R1: assert property (@(posedge clk) disable iff (rst)
        evt_bus[NUM_STROBES:1] == strb);

    // R4: cycle counter steps every edge when not written
    assert_cycle_step_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADDR_W'(IDX_CYCLE))
        |=> cnt_all[IDX_CYCLE] == $past(cnt_all[IDX_CYCLE]) + CNT_W'(1));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        if (kind_of(i) != CNT_NONE) begin : g_live
            // R9: a write wins over any increment
            assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == ADDR_W'(i))
                |=> cnt_all[i] == $past(wr_data));
        end
        if (kind_of(i) == CNT_EVENT) begin : g_evt
            // R6: never more than one step per edge
            assert_step_le1_R6: assert property (@(posedge clk) disable iff (rst)
                !(wr_en && wr_addr == ADDR_W'(i))
                |=> (cnt_all[i] == $past(cnt_all[i]) ||
                     cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1)));

            // R6: selected slot high means exactly one step
            assert_event_step_R6: assert property (@(posedge clk) disable iff (rst)
                (!(wr_en && wr_addr == ADDR_W'(i)) && sel_all[i] != '0 &&
                 sel_all[i] < SEL_W'(BUS_W) && evt_bus[sel_all[i][BIDX_W-1:0]])
                |=> cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1));

            // R7: a zero selector holds the counter
            assert_sel_zero_idle_R7: assert property (@(posedge clk) disable iff (rst)
                (sel_all[i] == '0 && !(wr_en && wr_addr == ADDR_W'(i)))
                |=> cnt_all[i] == $past(cnt_all[i]));
        end
    end
endmodule

bind perf_counter_bank perf_counter_bank_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .strb    (bp_evt_strb),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .evt_bus (evt_bus),
    .cnt_all (cnt_all),
    .sel_all (sel_all)
);

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;
    localparam int NS = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] strb = '0;
    logic          retire = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [63:0]   wr_data = '0;
    logic [4:0]    rd_addr = '0;
    logic [63:0]   rd_data;
    logic [255:0]  evt_bus;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    perf_counter_bank i_perf_counter_bank (
        .clk         (clk),
        .rst         (rst),
        .bp_evt_strb (strb),
        .retire      (retire),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .evt_bus     (evt_bus)
    );

    // Reference model built from the requirements.
    logic [63:0] mc [16];
    logic [8:0]  ms [16];

    initial begin
        for (int i = 0; i < 16; i++) begin
            mc[i] = '0;
            ms[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) begin
                mc[i] = '0;
                ms[i] = '0;
            end
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (i == 1) continue;
                if (wr_en && wr_addr == 5'(i)) begin
                    mc[i] = wr_data;
                end else if (i == 0) begin
                    mc[i] = mc[i] + 64'd1;
                end else if (i == 2) begin
                    if (retire) mc[i] = mc[i] + 64'd1;
                end else if (ms[i] >= 9'd1 && ms[i] <= 9'(NS)) begin
                    if (strb[ms[i] - 9'd1]) mc[i] = mc[i] + 64'd1;
                end
            end
            for (int i = 3; i < 16; i++) begin
                if (wr_en && wr_addr == 5'(16 + i)) ms[i] = wr_data[8:0];
            end
        end
    end

    // Scoreboard queue.
    typedef struct {
        logic [4:0]  addr;
        logic [63:0] exp;
        string       req;
    } item_t;
    item_t sbq[$];

    task automatic probe(input logic [4:0] a, input string req);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        it.addr = a;
        it.exp  = a[4] ? 64'(ms[a[3:0]]) : mc[a[3:0]];
        it.req  = req;
        sbq.push_back(it);
    endtask

    // Monitor: pops expected items and compares in the same low phase.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                n_checks++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%0h actual=%0h expected=%0h",
                             it.req, it.addr, rd_data, it.exp);
                end
            end
        end
    end

    task automatic lit_check(input logic [4:0] a, input logic [63:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        n_checks++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0h actual=%0h expected=%0h", req, a, rd_data, exp);
        end
    endtask

    task automatic sw_write(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic bus_check(input logic [NS-1:0] s, input string req);
        logic [255:0] exp;
        @(negedge clk);
        strb = s;
        #1;
        exp = '0;
        for (int k = 0; k < NS; k++) exp[k+1] = s[k];
        n_checks++;
        if (evt_bus !== exp) begin
            n_fail++;
            $display("FAIL %s bus actual=%0h expected=%0h", req, evt_bus, exp);
        end
    endtask

    task automatic pulse(input logic [NS-1:0] s, input int cycles);
        @(negedge clk);
        strb = s;
        repeat (cycles) @(negedge clk);
        strb = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        lit_check(5'd3, 64'd0, "R10 counter3");
        lit_check(5'd19, 64'd0, "R10 selector3");
        lit_check(5'd2, 64'd0, "R10 retired");
        probe(5'd0, "R4 cycle after reset");

        // R1 R2 R3: remap under several patterns
        bus_check(20'h00001, "R1 strobe0");
        bus_check(20'h80000, "R1 strobe19");
        bus_check(20'hFFFFF, "R2 R3 all strobes");
        bus_check(20'h5A5A5, "R1 mixed");
        @(negedge clk);
        strb = '0;

        // Selector programming
        sw_write(5'd19, 64'd1);            // counter3 <- slot 1 (strobe0)
        sw_write(5'd20, 64'd20);           // counter4 <- slot 20 (strobe19)
        sw_write(5'd21, 64'd0);            // counter5 idle
        sw_write(5'd22, 64'd21);           // counter6 tied slot
        sw_write(5'd23, 64'd300);          // counter7 out of range
        sw_write(5'd24, 64'd5);            // counter8 <- strobe4
        sw_write(5'd25, 64'd256);          // counter9 just out of range
        sw_write(5'd26, 64'hFFFF_FE0B);    // counter10 gets low 9 bits = 11
        sw_write(5'd17, 64'd7);            // reserved selector: ignored
        sw_write(5'd1, 64'd99);            // reserved counter: ignored
        lit_check(5'd19, 64'd1, "R9 selector load");
        lit_check(5'd23, 64'd300, "R9 selector 9-bit");
        lit_check(5'd26, 64'd11, "R9 selector low bits");
        lit_check(5'd17, 64'd0, "R11 reserved selector");
        lit_check(5'd1, 64'd0, "R11 reserved counter");

        // R6 R7: all strobes for five cycles
        pulse(20'hFFFFF, 5);
        lit_check(5'd3, 64'd5, "R6 counter3 burst");
        lit_check(5'd4, 64'd5, "R6 counter4 burst");
        lit_check(5'd5, 64'd0, "R7 selector zero");
        lit_check(5'd6, 64'd0, "R7 tied slot");
        lit_check(5'd7, 64'd0, "R7 selector 300");
        lit_check(5'd9, 64'd0, "R7 selector 256");
        probe(5'd8, "R6 counter8");

        // Sparse patterns with retire toggling
        @(negedge clk);
        retire = 1'b1;
        pulse(20'h00010, 3);
        retire = 1'b0;
        pulse(20'h00401, 2);
        probe(5'd3, "R6 counter3 sparse");
        probe(5'd8, "R6 counter8 sparse");
        probe(5'd10, "R6 counter10 sparse");
        probe(5'd2, "R5 retired");

        // R8: wrap
        sw_write(5'd4, 64'hFFFF_FFFF_FFFF_FFFF);
        pulse(20'h80000, 1);
        lit_check(5'd4, 64'd0, "R8 wrap");

        // R9: write beats increment
        @(negedge clk);
        strb    = 20'hFFFFF;
        wr_en   = 1'b1;
        wr_addr = 5'd3;
        wr_data = 64'h1234;
        @(negedge clk);
        wr_en   = 1'b0;
        strb    = '0;
        lit_check(5'd3, 64'h1234, "R9 write priority");

        // R4 R12: cycle counter load then comb reads
        sw_write(5'd0, 64'd1000);
        probe(5'd0, "R4 cycle after write");
        probe(5'd2, "R12 read switch");
        probe(5'd19, "R12 selector read");

        // R10: reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lit_check(5'd3, 64'd0, "R10 counter3 rst");
        lit_check(5'd20, 64'd0, "R10 selector4 rst");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule